// File: doc/BRIEF.md
# Two-Wire Port Byte Buffer and Address Register

This block is the firmware-facing data path of one two-wire serial port. Firmware sees three byte-wide registers: a data register, a slave-address register and a bit-rate register. The data register is split: a write feeds the transmit side, and a read returns the last byte received. Both sides share one 8-bit shift register. The bit-rate register is held here and driven out to an external reload timer. The bus timing itself is not computed here.

A bus sequencer outside the block supplies a one-cycle bit strobe, a start indication and a 2-bit mode. In the transmit modes, an accepted data write starts an 8-bit shift, most significant bit first, onto the serial output. In the receive modes, every strobe samples the serial input. After eight bits, the byte is copied into the receive buffer in one step. In slave-receive mode, the first byte after a start is not buffered. It is compared against the stored 7-bit address, and on a match the direction bit is captured.

The register addresses are parameters. The defaults are 9BH (data), 9AH (slave address) and 9CH (bit rate). A second port instance uses D2H, D1H and D3H.

Top module: `twi_byte_path`

## Requirements
- R1: After reset, the following are all zero: every register readback, `busy`, `rx_done`, `wcol`, `addr_hit`, `rw_dir` and `rate_sel`. `sda_out` is 1.
- R2: A write to the slave-address register (default 9AH) stores `reg_wdata[7:1]`, and reads return that value with bit 0 forced to 0. A write to the bit-rate register (default 9CH) is read back unchanged and drives `rate_sel`. A read of any other unmapped address returns 00H.
- R3: The data address (default 9BH) has separate write and read paths. A written byte is never read back. Reads return the receive buffer.
- R4: `mode` encoding is 0 for master transmit, 1 for slave transmit, 2 for master receive and 3 for slave receive. In modes 0 and 1, a data write accepted while `busy` is 0 raises `busy` on the next cycle and puts bit 7 on `sda_out`. Each `bit_tick` moves to the next lower bit. After the eighth tick, `busy` falls and `sda_out` returns to 1.
- R5: A data write while `busy` is 1 is ignored, so the byte on the wire continues unchanged, and it sets `wcol`. The next accepted data write clears `wcol`.
- R6: In modes 2 and 3, each `bit_tick` samples `sda_in`, most significant bit first. On the cycle after the eighth tick, the assembled byte is in the receive buffer and `rx_done` is 1.
- R7: A read of the data address clears `rx_done`. If that read falls on the same cycle as a buffer load, `rx_done` stays 1.
- R8: In mode 3, the first byte after `start_seen` is compared on bits 7:1 with the stored slave address. A match sets `addr_hit` and loads bit 0 into `rw_dir`. A mismatch clears `addr_hit` and leaves `rw_dir` unchanged. That byte does not enter the receive buffer and does not set `rx_done`. Later bytes are buffered as in R6.
- R9: In the receive modes, `start_seen` restarts the bit count, so the next byte completes after exactly eight further ticks.
- R10: In the receive modes, `busy` stays 0 and `sda_out` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clears `rx_done` on a data read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| mode | input | 2 | 0 master tx, 1 slave tx, 2 master rx, 3 slave rx |
| bit_tick | input | 1 | One-cycle strobe per bus bit |
| start_seen | input | 1 | One-cycle start indication |
| sda_in | input | 1 | Serial data sampled in receive modes |
| sda_out | output | 1 | Serial data driven in transmit modes, 1 when idle |
| busy | output | 1 | Transmit byte in progress |
| rx_done | output | 1 | Receive buffer holds an unread byte |
| wcol | output | 1 | Data write was rejected while busy |
| addr_hit | output | 1 | Last address byte matched |
| rw_dir | output | 1 | Direction bit of the last matching address byte |
| rate_sel | output | 8 | Bit-rate reload value for the external timer |

## Verification
The assertions assume three things about the inputs. First, `mode` changes only between bytes, while `busy` is low and no receive byte is partly shifted. Second, `start_seen` never coincides with the eighth strobe of a byte. Third, `bit_tick` is a single-cycle pulse. The directed stimulus follows these rules: it sets the mode before each scenario, pulses `start_seen` on a cycle of its own, and raises each strobe for exactly one cycle. The one deliberate overlap is a data read placed on the same cycle as the eighth receive strobe, which exercises R7.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [1:0] {
        MODE_MTX = 2'd0,
        MODE_STX = 2'd1,
        MODE_MRX = 2'd2,
        MODE_SRX = 2'd3
    } twi_mode_e;

    // Upper mode bit selects the receive direction
    function automatic logic mode_is_rx(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/twi_shift_unit.sv
module twi_shift_unit #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic            bit_tick,
    input  logic            start_seen,
    input  logic            load,
    input  logic [BITS-1:0] load_data,
    input  logic            sda_in,
    output logic            sda_out,
    output logic            busy,
    output logic            byte_done,
    output logic [BITS-1:0] byte_val
);
    import twi_pkg::*;

    localparam int CW = $clog2(BITS);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    typedef struct packed {
        logic [BITS-1:0] shreg;
        logic [CW-1:0]   cnt;
        logic            busy;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic [CW-1:0] cnt_base;
    logic          rx;

    always_comb begin
        st_d      = st_q;
        rx        = mode_is_rx(mode);
        cnt_base  = start_seen ? '0 : st_q.cnt;
        byte_done = 1'b0;
        byte_val  = {st_q.shreg[BITS-2:0], sda_in};
        if (rx) begin
            st_d.busy = 1'b0;
            st_d.cnt  = cnt_base;
            if (bit_tick) begin
                st_d.shreg = byte_val;
                if (cnt_base == LAST) begin
                    st_d.cnt  = '0;
                    byte_done = 1'b1;
                end else begin
                    st_d.cnt = cnt_base + 1'b1;
                end
            end
        end else if (load) begin
            st_d.shreg = load_data;
            st_d.busy  = 1'b1;
            st_d.cnt   = '0;
        end else if (st_q.busy && bit_tick) begin
            st_d.shreg = {st_q.shreg[BITS-2:0], 1'b0};
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign sda_out = (!mode_is_rx(mode) && st_q.busy) ? st_q.shreg[BITS-1] : 1'b1;

endmodule

// File: rtl/twi_addr_match.sv
module twi_addr_match #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic            start_seen,
    input  logic            byte_done,
    input  logic [BITS-1:0] byte_val,
    input  logic [BITS-2:0] own_addr,
    output logic            addr_byte,
    output logic            addr_hit,
    output logic            rw_dir
);
    import twi_pkg::*;

    typedef struct packed {
        logic addr_phase;
        logic hit;
        logic rw;
    } match_st_t;

    match_st_t st_d, st_q;
    logic      srx;

    always_comb begin
        st_d      = st_q;
        addr_byte = 1'b0;
        srx       = (mode == MODE_SRX);
        if (start_seen) begin
            st_d.addr_phase = srx;
            st_d.hit        = 1'b0;
        end else if (byte_done && st_q.addr_phase && srx) begin
            addr_byte       = 1'b1;
            st_d.addr_phase = 1'b0;
            st_d.hit        = (byte_val[BITS-1:1] == own_addr);
            if (byte_val[BITS-1:1] == own_addr) st_d.rw = byte_val[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_hit = st_q.hit;
    assign rw_dir   = st_q.rw;

endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank #(
    parameter int              BITS      = 8,
    parameter int              AW        = 8,
    parameter logic [AW-1:0]   DATA_ADDR = 8'h9B,
    parameter logic [AW-1:0]   SADR_ADDR = 8'h9A,
    parameter logic [AW-1:0]   RATE_ADDR = 8'h9C
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic            wr,
    input  logic            rd,
    input  logic [BITS-1:0] wdata,
    output logic [BITS-1:0] rdata,
    input  logic            busy,
    input  logic            rx_load,
    input  logic [BITS-1:0] rx_byte,
    output logic            tx_load,
    output logic [BITS-1:0] rate,
    output logic [BITS-2:0] own_addr,
    output logic            rx_done,
    output logic            wcol
);
    typedef struct packed {
        logic [BITS-1:0] rate;
        logic [BITS-2:0] saddr;
        logic [BITS-1:0] rxbuf;
        logic            rx_done;
        logic            wcol;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     data_sel;

    always_comb begin
        st_d     = st_q;
        data_sel = (addr == DATA_ADDR);
        tx_load  = wr && data_sel && !busy;
        if (wr && addr == RATE_ADDR) st_d.rate  = wdata;
        if (wr && addr == SADR_ADDR) st_d.saddr = wdata[BITS-1:1];
        if (wr && data_sel)          st_d.wcol  = busy;
        if (rd && data_sel)          st_d.rx_done = 1'b0;
        if (rx_load) begin
            st_d.rxbuf   = rx_byte;
            st_d.rx_done = 1'b1;
        end
        if (data_sel)                rdata = st_q.rxbuf;
        else if (addr == SADR_ADDR)  rdata = {st_q.saddr, 1'b0};
        else if (addr == RATE_ADDR)  rdata = st_q.rate;
        else                         rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rate     = st_q.rate;
    assign own_addr = st_q.saddr;
    assign rx_done  = st_q.rx_done;
    assign wcol     = st_q.wcol;

endmodule

// File: rtl/twi_byte_path.sv
module twi_byte_path #(
    parameter int            BITS      = 8,
    parameter int            AW        = 8,
    parameter logic [AW-1:0] DATA_ADDR = 8'h9B,
    parameter logic [AW-1:0] SADR_ADDR = 8'h9A,
    parameter logic [AW-1:0] RATE_ADDR = 8'h9C
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [BITS-1:0] reg_wdata,
    output logic [BITS-1:0] reg_rdata,
    input  logic [1:0]      mode,
    input  logic            bit_tick,
    input  logic            start_seen,
    input  logic            sda_in,
    output logic            sda_out,
    output logic            busy,
    output logic            rx_done,
    output logic            wcol,
    output logic            addr_hit,
    output logic            rw_dir,
    output logic [BITS-1:0] rate_sel
);
    logic            tx_load;
    logic            byte_done;
    logic [BITS-1:0] byte_val;
    logic [BITS-2:0] own_addr;
    logic            addr_byte;
    logic            rx_load;

    // Address bytes are consumed by the matcher, not buffered
    assign rx_load = byte_done && !addr_byte;

    twi_reg_bank #(
        .BITS(BITS), .AW(AW),
        .DATA_ADDR(DATA_ADDR), .SADR_ADDR(SADR_ADDR), .RATE_ADDR(RATE_ADDR)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .busy(busy), .rx_load(rx_load), .rx_byte(byte_val),
        .tx_load(tx_load), .rate(rate_sel), .own_addr(own_addr),
        .rx_done(rx_done), .wcol(wcol)
    );

    twi_shift_unit #(.BITS(BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .bit_tick(bit_tick), .start_seen(start_seen),
        .load(tx_load), .load_data(reg_wdata), .sda_in(sda_in),
        .sda_out(sda_out), .busy(busy),
        .byte_done(byte_done), .byte_val(byte_val)
    );

    twi_addr_match #(.BITS(BITS)) u_match (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .start_seen(start_seen), .byte_done(byte_done),
        .byte_val(byte_val), .own_addr(own_addr),
        .addr_byte(addr_byte), .addr_hit(addr_hit), .rw_dir(rw_dir)
    );

endmodule

// File: rtl/twi_byte_path_chk.sv
module twi_byte_path_chk #(
    parameter int            AW        = 8,
    parameter logic [AW-1:0] DATA_ADDR = 8'h9B
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] reg_addr,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [1:0]    mode,
    input logic          bit_tick,
    input logic          sda_out,
    input logic          busy,
    input logic          rx_done,
    input logic          wcol,
    input logic          addr_hit
);
    // Idle or receiving: line released
    assert_line_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || mode[1]) |-> sda_out);

    assert_tx_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == DATA_ADDR && !busy && !mode[1]) |=> busy);

    assert_no_busy_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && $past(mode[1])) |-> !busy);

    assert_wcol_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == DATA_ADDR && busy) |=> wcol);

    assert_ignored_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == DATA_ADDR && busy && !bit_tick && !mode[1]) |=> $stable(sda_out));

    assert_rx_from_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(bit_tick));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == DATA_ADDR && !bit_tick) |=> !rx_done);

    assert_hit_in_srx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_hit) |-> ($past(bit_tick) && $past(mode) == 2'd3));

endmodule

bind twi_byte_path twi_byte_path_chk #(.AW(AW), .DATA_ADDR(DATA_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .mode(mode), .bit_tick(bit_tick), .sda_out(sda_out),
    .busy(busy), .rx_done(rx_done), .wcol(wcol), .addr_hit(addr_hit)
);

// File: tb/twi_byte_path_test.sv
`timescale 1ns/1ps
module twi_byte_path_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] mode = 2'd0;
    logic       bit_tick = 1'b0, start_seen = 1'b0, sda_in = 1'b0;
    logic       sda_out, busy, rx_done, wcol, addr_hit, rw_dir;
    logic [7:0] rate_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [7:0] A_DATA = 8'h9B, A_SADR = 8'h9A, A_RATE = 8'h9C;

    always #4 clk = ~clk;

    twi_byte_path uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mode(mode), .bit_tick(bit_tick), .start_seen(start_seen),
        .sda_in(sda_in), .sda_out(sda_out), .busy(busy), .rx_done(rx_done),
        .wcol(wcol), .addr_hit(addr_hit), .rw_dir(rw_dir), .rate_sel(rate_sel)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        cyc();
        reg_rd = 1'b0;
    endtask

    task automatic tick(input logic b);
        sda_in = b; bit_tick = 1'b1;
        cyc();
        bit_tick = 1'b0;
    endtask

    task automatic pulse_start();
        start_seen = 1'b1;
        cyc();
        start_seen = 1'b0;
    endtask

    task automatic rx_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) tick(v[i]);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd_reg(A_DATA, v); check("R1 data", v, 8'h00);
        rd_reg(A_SADR, v); check("R1 sadr", v, 8'h00);
        rd_reg(A_RATE, v); check("R1 rate", v, 8'h00);
        check("R1 flags", {2'b0, busy, rx_done, wcol, addr_hit, rw_dir, sda_out}, 8'h01);
        check("R1 rate_sel", rate_sel, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr_reg(A_SADR, 8'hA5);
        rd_reg(A_SADR, v); check("R2 sadr bit0 zero", v, 8'hA4);
        wr_reg(A_RATE, 8'h37);
        rd_reg(A_RATE, v); check("R2 rate readback", v, 8'h37);
        check("R2 rate_sel", rate_sel, 8'h37);
        rd_reg(8'h55, v); check("R2 unmapped", v, 8'h00);
    endtask

    task automatic t_tx();
        logic [7:0] v;
        logic [7:0] b = 8'hB4;
        mode = 2'd0;
        wr_reg(A_DATA, b);
        check("R4 busy up", {7'b0, busy}, 8'h01);
        for (int i = 7; i >= 0; i--) begin
            check("R4 bit", {7'b0, sda_out}, {7'b0, b[i]});
            tick(1'b0);
        end
        check("R4 busy down", {7'b0, busy}, 8'h00);
        check("R4 line idle", {7'b0, sda_out}, 8'h01);
        rd_reg(A_DATA, v); check("R3 write not read back", v, 8'h00);
    endtask

    task automatic t_wcol();
        logic [7:0] b = 8'h3C;
        mode = 2'd1;
        wr_reg(A_DATA, b);
        tick(1'b0); tick(1'b0);
        wr_reg(A_DATA, 8'hFF);
        check("R5 wcol set", {7'b0, wcol}, 8'h01);
        for (int i = 5; i >= 0; i--) begin
            check("R5 byte unchanged", {7'b0, sda_out}, {7'b0, b[i]});
            tick(1'b0);
        end
        check("R5 finished", {7'b0, busy}, 8'h00);
        wr_reg(A_DATA, 8'h81);
        check("R5 wcol cleared", {7'b0, wcol}, 8'h00);
        check("R5 new byte starts", {7'b0, sda_out}, 8'h01);
        for (int i = 0; i < 8; i++) tick(1'b0);
    endtask

    task automatic t_rx();
        logic [7:0] v;
        mode = 2'd2;
        for (int i = 7; i >= 1; i--) tick(8'h96 >> i);
        check("R6 not yet done", {7'b0, rx_done}, 8'h00);
        check("R10 busy low", {7'b0, busy}, 8'h00);
        check("R10 line released", {7'b0, sda_out}, 8'h01);
        tick(1'b0);
        check("R6 rx_done", {7'b0, rx_done}, 8'h01);
        rd_reg(A_DATA, v); check("R6 rx byte", v, 8'h96);
        check("R7 cleared by read", {7'b0, rx_done}, 8'h00);
        for (int i = 7; i >= 1; i--) tick(8'h4D >> i);
        reg_addr = A_DATA; reg_rd = 1'b1; sda_in = 1'b1; bit_tick = 1'b1;
        cyc();
        reg_rd = 1'b0; bit_tick = 1'b0;
        check("R7 load wins", {7'b0, rx_done}, 8'h01);
        rd_reg(A_DATA, v); check("R7 byte", v, 8'h4D);
    endtask

    task automatic t_addr();
        logic [7:0] v, prior;
        wr_reg(A_SADR, 8'h5A);
        rd_reg(A_DATA, prior);
        mode = 2'd3;
        pulse_start();
        rx_byte(8'h5B);
        check("R8 hit", {7'b0, addr_hit}, 8'h01);
        check("R8 rw", {7'b0, rw_dir}, 8'h01);
        check("R8 no rx_done", {7'b0, rx_done}, 8'h00);
        rd_reg(A_DATA, v); check("R8 buffer untouched", v, prior);
        rx_byte(8'h11);
        check("R8 data byte done", {7'b0, rx_done}, 8'h01);
        rd_reg(A_DATA, v); check("R8 data byte", v, 8'h11);
        pulse_start();
        rx_byte(8'h5C);
        check("R8 miss", {7'b0, addr_hit}, 8'h00);
        check("R8 rw kept", {7'b0, rw_dir}, 8'h01);
    endtask

    task automatic t_restart();
        logic [7:0] v;
        mode = 2'd2;
        tick(1'b1); tick(1'b0); tick(1'b1);
        pulse_start();
        for (int i = 7; i >= 1; i--) tick(8'hC3 >> i);
        check("R9 seven after start", {7'b0, rx_done}, 8'h00);
        tick(1'b1);
        check("R9 eighth after start", {7'b0, rx_done}, 8'h01);
        rd_reg(A_DATA, v); check("R9 byte", v, 8'hC3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_regs();
        t_tx();
        t_wcol();
        t_rx();
        t_addr();
        t_restart();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule